// File: doc/BRIEF.md
# Receive-Enable Mask Arbiter

This block holds an eight-bit receiver-enable mask. Two independent agents can change it. A radio command processor issues one-cycle command strobes, and each strobe sets or clears fixed bits. The CPU writes through two bus ports: a set port that turns mask bits on and a clear port that turns them off. Whenever the mask holds any nonzero value, a registered receive-request line asks the radio state machine to keep its receiver enabled.

The two agents may act in the same clock cycle, so the block resolves conflicts bit by bit. A bus write claims only the bits where its data is 1. Every other bit takes the result of the strobe. If the set port and the clear port both claim a bit, the clear port wins. A one-bit configuration flag, readable and writable by the CPU, decides whether the transmit-on strobe also marks the mask. The mask itself can only be read by software. Every update takes effect on the next rising clock edge.

Top module: `rx_mask_arbiter`

## Requirements
- R1: While reset is asserted and right after it is released, mask_q is 0x00, rx_req is 0 and tx_mark_q is 1.
- R2: A strobe with cmd_op = 0 (receive-on) sets mask bit 7 and leaves the other bits unchanged.
- R3: A strobe with cmd_op = 1 (transmit-on) sets mask bit 6 when tx_mark_q is 1. When tx_mark_q is 0 it leaves the mask unchanged.
- R4: A strobe with cmd_op = 2 (RF-off) clears all eight mask bits.
- R5: A strobe with cmd_op = 3 sets mask bit 5, and cmd_op = 4 clears mask bit 5. Codes 5 to 7 have no effect on the mask. With cmd_valid low, cmd_op is ignored.
- R6: A set-port write ORs set_data into the mask.
- R7: A clear-port write clears every mask bit where clr_data is 1. When both ports claim the same bit in one cycle, that bit ends up 0.
- R8: When a strobe and a bus write occur in the same cycle, each bit where set_data or clr_data (of an active port) is 1 takes the bus result. Every other bit takes the strobe result.
- R9: rx_req is 1 exactly when mask_q is nonzero, and it changes in the same cycle as mask_q.
- R10: A write with cfg_wr = 1 loads cfg_wdata into tx_mark_q on the next edge. A transmit-on strobe in that same cycle uses the old flag value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | One-cycle strobe qualifier |
| cmd_op | input | 3 | Strobe code (0 rx-on, 1 tx-on, 2 rf-off, 3 bit-5 set, 4 bit-5 clear) |
| set_wr | input | 1 | Bus write to the set port |
| set_data | input | 8 | Bits to set |
| clr_wr | input | 1 | Bus write to the clear port |
| clr_data | input | 8 | Bits to clear |
| cfg_wr | input | 1 | Write to the transmit-marks flag |
| cfg_wdata | input | 1 | New value of the flag |
| tx_mark_q | output | 1 | Current flag: transmit-on strobe marks bit 6 |
| mask_q | output | 8 | Mask readback |
| rx_req | output | 1 | Receive request, high while the mask is nonzero |

## Verification
The bench goes after conflicts in which a strobe and a bus write hit overlapping bits and disjoint bits. A design that let the bus override the whole register would wipe out the strobe's bits on disjoint positions. A design that let the strobe win would keep bits that software had cleared. Both ports claiming one bit catches a set-wins ordering. Undefined codes, a disabled transmit-marks flag, and a flag write coinciding with a transmit-on strobe catch a decoder that marks too eagerly or reads the new flag value early. The receive request is compared against the mask every cycle, which exposes a request taken from the old mask and so lagging by one cycle.

// File: rtl/rxm_pkg.sv
package rxm_pkg;
    localparam int MASK_W = 8;
    localparam int OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_RX_ON   = 3'd0,
        OP_TX_ON   = 3'd1,
        OP_RF_OFF  = 3'd2,
        OP_AUX_SET = 3'd3,
        OP_AUX_CLR = 3'd4
    } rxm_op_e;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic              tx_marks;
        logic              req;
    } rxm_state_t;
endpackage

// File: rtl/rxm_strobe_unit.sv
module rxm_strobe_unit
    import rxm_pkg::*;
#(
    parameter int RXON_BIT = 7,
    parameter int TXON_BIT = 6,
    parameter int AUX_BIT  = 5
) (
    input  logic [MASK_W-1:0] mask_i,
    input  logic              valid_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic              tx_marks_i,
    output logic [MASK_W-1:0] strobe_mask_o
);
    always_comb begin
        strobe_mask_o = mask_i;
        if (valid_i) begin
            case (rxm_op_e'(op_i))
                OP_RX_ON:   strobe_mask_o[RXON_BIT] = 1'b1;
                OP_TX_ON:   if (tx_marks_i) strobe_mask_o[TXON_BIT] = 1'b1;
                OP_RF_OFF:  strobe_mask_o = '0;
                OP_AUX_SET: strobe_mask_o[AUX_BIT] = 1'b1;
                OP_AUX_CLR: strobe_mask_o[AUX_BIT] = 1'b0;
                default:    strobe_mask_o = mask_i;
            endcase
        end
    end
endmodule

// File: rtl/rxm_bus_merge.sv
module rxm_bus_merge
    import rxm_pkg::*;
(
    input  logic [MASK_W-1:0] strobe_mask_i,
    input  logic              set_wr_i,
    input  logic [MASK_W-1:0] set_data_i,
    input  logic              clr_wr_i,
    input  logic [MASK_W-1:0] clr_data_i,
    output logic [MASK_W-1:0] next_mask_o
);
    logic [MASK_W-1:0] set_eff;
    logic [MASK_W-1:0] clr_eff;

    assign set_eff = set_wr_i ? set_data_i : '0;
    assign clr_eff = clr_wr_i ? clr_data_i : '0;

    for (genvar i = 0; i < MASK_W; i++) begin : g_bit
        logic claimed;
        assign claimed = set_eff[i] | clr_eff[i];
        // a claimed bit follows the bus (clear over set); others follow the strobe
        assign next_mask_o[i] = claimed ? ~clr_eff[i] : strobe_mask_i[i];
    end

    always_comb begin
        assert (((next_mask_o & clr_eff) == '0)) else $error("assert_clear_dominates_R7");
    end
endmodule

// File: rtl/rx_mask_arbiter.sv
module rx_mask_arbiter
    import rxm_pkg::*;
#(
    parameter int   RXON_BIT  = 7,
    parameter int   TXON_BIT  = 6,
    parameter int   AUX_BIT   = 5,
    parameter logic CFG_RESET = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic              set_wr,
    input  logic [MASK_W-1:0] set_data,
    input  logic              clr_wr,
    input  logic [MASK_W-1:0] clr_data,
    input  logic              cfg_wr,
    input  logic              cfg_wdata,
    output logic              tx_mark_q,
    output logic [MASK_W-1:0] mask_q,
    output logic              rx_req
);
    rxm_state_t st_d, st_q;
    logic [MASK_W-1:0] strobe_mask;
    logic [MASK_W-1:0] merged_mask;

    rxm_strobe_unit #(
        .RXON_BIT(RXON_BIT),
        .TXON_BIT(TXON_BIT),
        .AUX_BIT (AUX_BIT)
    ) u_strobe (
        .mask_i       (st_q.mask),
        .valid_i      (cmd_valid),
        .op_i         (cmd_op),
        .tx_marks_i   (st_q.tx_marks),
        .strobe_mask_o(strobe_mask)
    );

    rxm_bus_merge u_merge (
        .strobe_mask_i(strobe_mask),
        .set_wr_i     (set_wr),
        .set_data_i   (set_data),
        .clr_wr_i     (clr_wr),
        .clr_data_i   (clr_data),
        .next_mask_o  (merged_mask)
    );

    always_comb begin
        st_d      = st_q;
        st_d.mask = merged_mask;
        st_d.req  = |merged_mask;
        if (cfg_wr) st_d.tx_marks = cfg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mask: '0, tx_marks: CFG_RESET, req: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_q    = st_q.mask;
    assign rx_req    = st_q.req;
    assign tx_mark_q = st_q.tx_marks;

    logic bus_idle;
    logic [MASK_W-1:0] set_only;
    assign bus_idle = !set_wr && !clr_wr;
    assign set_only = (set_wr ? set_data : '0) & ~(clr_wr ? clr_data : '0);

    assert_rxon_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_RX_ON && bus_idle) |=> mask_q[RXON_BIT]);

    assert_txoff_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_TX_ON && !tx_mark_q && bus_idle) |=> $stable(mask_q));

    assert_rfoff_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_RF_OFF && bus_idle) |=> (mask_q == '0));

    assert_setport_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> ((mask_q & $past(set_only)) == $past(set_only)));

    assert_clrport_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((mask_q & $past(clr_data)) == '0));

    assert_req_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_req == (mask_q != '0));

    assert_cfg_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (tx_mark_q == $past(cfg_wdata)));
endmodule

// File: tb/rx_mask_arbiter_test.sv
module rx_mask_arbiter_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic       set_wr = 1'b0;
    logic [7:0] set_data = 8'h00;
    logic       clr_wr = 1'b0;
    logic [7:0] clr_data = 8'h00;
    logic       cfg_wr = 1'b0;
    logic       cfg_wdata = 1'b0;
    logic       tx_mark_q;
    logic [7:0] mask_q;
    logic       rx_req;

    int checks = 0;
    int fails  = 0;
    logic [7:0] m_mask = 8'h00;
    logic       m_cfg  = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_mask_arbiter uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .set_wr(set_wr), .set_data(set_data), .clr_wr(clr_wr), .clr_data(clr_data),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .tx_mark_q(tx_mark_q),
        .mask_q(mask_q), .rx_req(rx_req)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // drive at negedge, clock once, compare at the following negedge
    task automatic step(input string tag, input logic v, input logic [2:0] op,
                        input logic sw, input logic [7:0] sd,
                        input logic cw, input logic [7:0] cd,
                        input logic fw, input logic fd);
        logic [7:0] s, se, ce, t;
        cmd_valid = v; cmd_op = op; set_wr = sw; set_data = sd;
        clr_wr = cw; clr_data = cd; cfg_wr = fw; cfg_wdata = fd;
        s = m_mask;
        if (v) begin
            case (op)
                3'd0: s = s | 8'h80;
                3'd1: if (m_cfg) s = s | 8'h40;
                3'd2: s = 8'h00;
                3'd3: s = s | 8'h20;
                3'd4: s = s & 8'hDF;
                default: ;
            endcase
        end
        se = sw ? sd : 8'h00;
        ce = cw ? cd : 8'h00;
        t  = se | ce;
        m_mask = (~ce & t) | (s & ~t);
        if (fw) m_cfg = fd;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0; set_wr = 1'b0; clr_wr = 1'b0; cfg_wr = 1'b0;
        check(tag, mask_q, m_mask);
        check("R9 request", {7'd0, rx_req}, {7'd0, m_mask != 8'h00});
        check("R10 flag", {7'd0, tx_mark_q}, {7'd0, m_cfg});
    endtask

    task automatic load(input logic [7:0] val);
        step("R7 load", 1'b0, 3'd0, 1'b1, val, 1'b1, ~val, 1'b0, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++; checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
    end

    initial begin
        logic [7:0] inits [5];
        logic [7:0] sdat  [5];
        logic [7:0] cdat  [5];
        string tag;
        inits = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h20};
        sdat  = '{8'h00, 8'h60, 8'h00, 8'h81, 8'hF0};
        cdat  = '{8'h00, 8'h00, 8'hA0, 8'h01, 8'h0F};
        repeat (3) @(negedge clk);
        check("R1 reset mask", mask_q, 8'h00);
        check("R1 reset req", {7'd0, rx_req}, 8'h00);
        check("R1 reset flag", {7'd0, tx_mark_q}, 8'h01);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", mask_q, 8'h00);

        // cfg written together with tx-on: old value governs the strobe
        step("R10 cfg+txon", 1'b1, 3'd1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0);
        load(8'h00);
        step("R10 cfg+txon", 1'b1, 3'd1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1);

        for (int c = 0; c < 2; c++) begin
            step("R10 cfg", 1'b0, 3'd0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, c[0]);
            for (int i = 0; i < 5; i++) begin
                for (int op = 0; op < 9; op++) begin
                    for (int b = 0; b < 5; b++) begin
                        load(inits[i]);
                        if (b == 0) begin
                            case (op)
                                0: tag = "R2 rx-on";
                                1: tag = "R3 tx-on";
                                2: tag = "R4 rf-off";
                                8: tag = "R5 no valid";
                                default: tag = "R5 bit5/undef";
                            endcase
                        end else if (op == 8) begin
                            tag = (b == 1) ? "R6 set port" : (b == 2) ? "R7 clr port" : "R7 both ports";
                        end else begin
                            tag = "R8 conflict";
                        end
                        step(tag, op != 8, 3'(op % 8), sdat[b] != 8'h00 || b == 3, sdat[b],
                             cdat[b] != 8'h00, cdat[b], 1'b0, 1'b0);
                    end
                end
            end
        end

        // overlapping claim on the same bit by both ports, strobe setting it too
        load(8'h00);
        step("R7 clear wins", 1'b1, 3'd0, 1'b1, 8'h80, 1'b1, 8'h80, 1'b0, 1'b0);
        step("R8 set over rf-off", 1'b1, 3'd2, 1'b1, 8'h02, 1'b0, 8'h00, 1'b0, 1'b0);

        rst_n = 1'b0;
        @(negedge clk);
        check("R1 re-reset", mask_q, 8'h00);
        check("R1 re-reset flag", {7'd0, tx_mark_q}, 8'h01);
        summary();
    end
endmodule